// File: doc/BRIEF.md
# Gated Four-Channel Coincidence Photon Counter

This block counts photon arrivals on four single-photon detector lines. It also counts how often several lines are active at the same time. Each detector line is synchronised and reduced to its rising edges. Each rising edge restarts a per-channel stretcher whose programmed length, in clock cycles, sets the coincidence window. Every channel has its own saturating counter of photon edges. Three further counters record each onset of "at least two", "at least three" and "all four" stretched channels being high together.

Counting is gated by a free-running bin timer. The timer runs through a programmable number of cycles per bin. Events are only accepted while the bin phase is below a programmable exposure length. On the last cycle of each bin, every counter's value is copied into a holding register. That copy includes any event arriving in that same cycle. In the same clock edge the live counters restart from zero, so no cycle between bins is lost. A one-cycle strobe then announces the fresh results. A host polls or interrupts on that strobe and reads the held counts and the per-counter overflow flags.

Top module: `photon_coinc_counter`

## Requirements
- R1: While reset is asserted and until the first bin closes, all held counts, all overflow flags and the result strobe read zero.
- R2: Every low-to-high transition of a detector input, where the input stays high for at least one clock and low for at least one clock between pulses, adds exactly one to that channel's count in the bin where it is registered.
- R3: A registered rising edge makes that channel's stretched pulse high for exactly cfg_width cycles, and a width of 0 acts as 1. Two channels whose inputs rise d cycles apart therefore coincide when d < width and do not coincide when d >= width.
- R4: A new rising edge while a channel's stretched pulse is still high reloads the full width from that edge, which extends the pulse.
- R5: Fold counter k (result slot k-2, for k = 2, 3, 4) adds one on each cycle where "at least k stretched channels high" becomes true after being false. A long overlap counts once, and a climb from two to three channels raises the 3-fold count without a second 2-fold count.
- R6: The bin phase runs 0 to cfg_cycle-1, and a cycle value of 0 acts as 1. An event is counted only if it is registered while the phase is below cfg_expose.
- R7: On the clock edge that ends phase cfg_cycle-1, all counts move to the outputs and the live counters restart at zero. The outputs then hold steady for the whole following bin, and res_valid is high for the single cycle after that edge, once per bin.
- R8: A single event is registered two clock edges after the edge that first samples the input high, and its fold event one edge later. An event registered in a bin's last cycle lands in that bin's result, and one registered in the next cycle lands in the next bin's result, so no cycle is blind.
- R9: A counter at all ones stays at all ones when further events arrive.
- R10: A counter's overflow flag (ovf_single bit per channel, ovf_fold bit per fold slot) is reported set with a bin's results when an event arrived while that counter was already at all ones. Reaching all ones exactly leaves it clear, and the flag starts clear in every new bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| det_in | input | NCH | Asynchronous detector lines, one per channel |
| cfg_width | input | PW_W | Stretched pulse length in cycles (0 acts as 1) |
| cfg_expose | input | TIME_W | Number of counting cycles at the start of each bin |
| cfg_cycle | input | TIME_W | Bin length in cycles (0 acts as 1) |
| cnt_single | output | NCH*CNT_W | Held per-channel counts, channel c in bits c*CNT_W upward |
| cnt_fold | output | (NCH-1)*CNT_W | Held fold counts, slot k-2 holds the k-fold count |
| ovf_single | output | NCH | Held per-channel overflow flags |
| ovf_fold | output | NCH-1 | Held per-fold overflow flags |
| res_valid | output | 1 | One-cycle strobe marking fresh held results |

## Verification
Because every bin's counts are copied out at the boundary, a wrong stretcher length, a fold counted per cycle instead of per onset, or a missed gate decision appears as a wrong number in the very next result, at most one bin after the stimulus. An error in bin turnover shows differently. A lost or doubled boundary cycle moves a single event between adjacent results. A stale counter that was not cleared makes an empty bin read non-zero. Saturation faults show only when more events than the counter range fall in one bin, so the counters are kept narrow to reach that case within a bin.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // Lowest coincidence order that has its own counter
    localparam int unsigned PCC_MIN_FOLD = 2;

    // Bin control issued by the timer every cycle
    typedef struct packed {
        logic gate;     // events in this cycle are counted
        logic bin_end;  // this is the last cycle of the bin
    } pcc_bin_t;

    // Number of set bits in a vector of up to 32 bits
    function automatic int unsigned pcc_ones(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += 32'(v[i]);
        end
        return n;
    endfunction

    // Effective value of a setting where zero means one
    function automatic logic [31:0] pcc_min1(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/pcc_shaper.sv
module pcc_shaper
    import pcc_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            det,
    input  logic [PW_W-1:0] width,
    output logic            trig,
    output logic            active
);
    logic            s1, s2, s3;
    logic [PW_W-1:0] rem;
    logic [PW_W-1:0] load_val;

    // two-stage synchroniser followed by one delay stage for the edge
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= det;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign trig     = s2 & ~s3;
    assign load_val = PW_W'(pcc_min1(32'(width)));

    // remaining stretch cycles; a new edge reloads the full width
    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (trig) begin
            rem <= load_val;
        end else if (rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    assign active = (rem != '0);

    // R3
    stretch_start_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> active)
        else $error("stretched pulse did not start after an edge");

endmodule

// File: rtl/pcc_fold_detect.sv
module pcc_fold_detect
    import pcc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] active,
    output logic [NCH-2:0] rise
);
    localparam int NFOLD = NCH - 1;

    int unsigned      hits;
    logic [NFOLD-1:0] lvl;
    logic [NFOLD-1:0] lvl_q;

    assign hits = pcc_ones(32'(active));

    for (genvar k = 0; k < NFOLD; k++) begin : g_lvl
        assign lvl[k] = (hits >= 32'(k + PCC_MIN_FOLD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl;
        end
    end

    // one event per onset of each fold level
    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/pcc_bin_timer.sv
module pcc_bin_timer
    import pcc_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] cfg_expose,
    input  logic [TIME_W-1:0] cfg_cycle,
    output pcc_bin_t          ctl
);
    logic [TIME_W-1:0] phase;
    logic [TIME_W:0]   phase_nxt;

    assign phase_nxt   = {1'b0, phase} + 1'b1;
    // zero cycle length behaves as one: every cycle ends a bin
    assign ctl.bin_end = (phase_nxt >= {1'b0, cfg_cycle});
    assign ctl.gate    = (phase < cfg_expose);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (ctl.bin_end) begin
            phase <= '0;
        end else begin
            phase <= phase_nxt[TIME_W-1:0];
        end
    end

endmodule

// File: rtl/pcc_sat_counter.sv
module pcc_sat_counter
    import pcc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  pcc_bin_t         ctl,
    output logic [CNT_W-1:0] hold,
    output logic             hold_ovf
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             ovf;
    logic             ovf_nxt;
    logic             take;
    logic             full;

    assign take    = inc & ctl.gate;
    assign full    = &cnt;
    assign cnt_nxt = (take && !full) ? cnt + 1'b1 : cnt;
    assign ovf_nxt = ovf | (take & full);

    // boundary cycle: its own event goes into the copy, counter restarts
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ovf      <= 1'b0;
            hold     <= '0;
            hold_ovf <= 1'b0;
        end else if (ctl.bin_end) begin
            cnt      <= '0;
            ovf      <= 1'b0;
            hold     <= cnt_nxt;
            hold_ovf <= ovf_nxt;
        end else begin
            cnt      <= cnt_nxt;
            ovf      <= ovf_nxt;
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.bin_end |=> cnt >= $past(cnt))
        else $error("counter decreased inside a bin");

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ctl.bin_end) |=> ovf)
        else $error("overflow flag dropped inside a bin");

endmodule

// File: rtl/photon_coinc_counter.sv
module photon_coinc_counter
    import pcc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int PW_W   = 8,
    parameter int TIME_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             det_in,
    input  logic [PW_W-1:0]            cfg_width,
    input  logic [TIME_W-1:0]          cfg_expose,
    input  logic [TIME_W-1:0]          cfg_cycle,
    output logic [NCH*CNT_W-1:0]       cnt_single,
    output logic [(NCH-1)*CNT_W-1:0]   cnt_fold,
    output logic [NCH-1:0]             ovf_single,
    output logic [NCH-2:0]             ovf_fold,
    output logic                       res_valid
);
    localparam int NFOLD = NCH - 1;

    pcc_bin_t         ctl;
    logic [NCH-1:0]   trig;
    logic [NCH-1:0]   active;
    logic [NFOLD-1:0] fold_rise;

    pcc_bin_timer #(.TIME_W(TIME_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cfg_expose (cfg_expose),
        .cfg_cycle  (cfg_cycle),
        .ctl        (ctl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pcc_shaper #(.PW_W(PW_W)) u_shape (
            .clk    (clk),
            .rst    (rst),
            .det    (det_in[c]),
            .width  (cfg_width),
            .trig   (trig[c]),
            .active (active[c])
        );

        pcc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .inc      (trig[c]),
            .ctl      (ctl),
            .hold     (cnt_single[c*CNT_W +: CNT_W]),
            .hold_ovf (ovf_single[c])
        );
    end

    pcc_fold_detect #(.NCH(NCH)) u_fold (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .rise   (fold_rise)
    );

    for (genvar k = 0; k < NFOLD; k++) begin : g_fold
        pcc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .inc      (fold_rise[k]),
            .ctl      (ctl),
            .hold     (cnt_fold[k*CNT_W +: CNT_W]),
            .hold_ovf (ovf_fold[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= ctl.bin_end;
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cfg_cycle > TIME_W'(1)) |=> !res_valid)
        else $error("result strobe longer than one cycle");

endmodule

// File: tb/photon_coinc_counter_test.sv
module photon_coinc_counter_test;
    localparam int NCH = 4;
    localparam int CW  = 4;
    localparam int PW  = 4;
    localparam int TW  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    det_in = '0;
    logic [PW-1:0]     cfg_width = 4'd1;
    logic [TW-1:0]     cfg_expose = 8'd64;
    logic [TW-1:0]     cfg_cycle = 8'd64;
    logic [NCH*CW-1:0] cnt_single;
    logic [(NCH-1)*CW-1:0] cnt_fold;
    logic [NCH-1:0]    ovf_single;
    logic [NCH-2:0]    ovf_fold;
    logic              res_valid;

    int  n_tot  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    int  es [NCH];
    int  ef [NCH-1];
    int  eo;
    logic [3:0] sched [0:39];

    always #2.5 clk = ~clk;

    photon_coinc_counter #(.NCH(NCH), .CNT_W(CW), .PW_W(PW), .TIME_W(TW)) uut (
        .clk(clk), .rst(rst), .det_in(det_in), .cfg_width(cfg_width),
        .cfg_expose(cfg_expose), .cfg_cycle(cfg_cycle),
        .cnt_single(cnt_single), .cnt_fold(cnt_fold),
        .ovf_single(ovf_single), .ovf_fold(ovf_fold), .res_valid(res_valid)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_tot++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        @(negedge clk);
        while (!res_valid) @(negedge clk);
    endtask

    // expected outcome for one simultaneous pulse on the channels of mask
    task automatic exp_mask(input logic [3:0] m);
        int pc;
        pc = 0;
        for (int c = 0; c < NCH; c++) begin
            es[c] = int'(m[c]);
            pc += int'(m[c]);
        end
        for (int k = 0; k < NCH-1; k++) ef[k] = (pc >= k + 2) ? 1 : 0;
        eo = 0;
    endtask

    task automatic check_bin(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(int'(cnt_single[c*CW +: CW]), es[c], $sformatf("%s single ch%0d", tag, c));
            chk(int'(ovf_single[c]), eo, $sformatf("%s ovf ch%0d", tag, c));
        end
        for (int k = 0; k < NCH-1; k++) begin
            chk(int'(cnt_fold[k*CW +: CW]), ef[k], $sformatf("%s fold%0d", tag, k+2));
            chk(int'(ovf_fold[k]), eo, $sformatf("%s ovf fold%0d", tag, k+2));
        end
    endtask

    task automatic clear_sched();
        for (int t = 0; t < 40; t++) sched[t] = 4'd0;
    endtask

    task automatic run_sched();
        for (int t = 0; t < 40; t++) begin
            det_in = sched[t];
            @(negedge clk);
        end
        det_in = '0;
    endtask

    task automatic pulse(input logic [3:0] m);
        det_in = m;
        @(negedge clk);
        det_in = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tot++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(int'(res_valid), 0, "R1 valid in reset");
        chk(int'(cnt_single), 0, "R1 singles in reset");
        chk(int'(cnt_fold), 0, "R1 folds in reset");
        chk(int'({ovf_single, ovf_fold}), 0, "R1 flags in reset");
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(int'(cnt_single), 0, "R1 singles before first bin");
        wait_valid();
        exp_mask(4'd0);
        check_bin("R1 empty bin");

        // R2 R5 sweep of all channel subsets, two widths
        for (int w = 1; w <= 4; w += 3) begin
            cfg_width = PW'(w);
            for (int m = 0; m < 16; m++) begin
                pulse(4'(m));
                wait_valid();
                exp_mask(4'(m));
                check_bin($sformatf("R2 R5 w%0d mask%0d", w, m));
            end
        end

        // R3 window edge: rises d apart coincide only when d < width
        for (int w = 0; w <= 3; w++) begin
            for (int dd = 0; dd <= 1; dd++) begin
                int we;
                int d;
                we = (w == 0) ? 1 : w;
                d  = we - 1 + dd;
                cfg_width = PW'(w);
                clear_sched();
                sched[0] = sched[0] | 4'b0001;
                sched[d] = sched[d] | 4'b0010;
                run_sched();
                wait_valid();
                exp_mask(4'b0011);
                ef[0] = (dd == 0) ? 1 : 0;
                check_bin($sformatf("R3 w%0d d%0d", w, d));
            end
        end

        // R4 retrigger extends the pulse into overlap with ch1
        cfg_width = 4'd6;
        clear_sched();
        sched[0] = 4'b0001;
        sched[4] = 4'b0001;
        sched[8] = 4'b0010;
        run_sched();
        wait_valid();
        exp_mask(4'b0011);
        es[0] = 2;
        ef[0] = 1;
        check_bin("R4 restart");

        // R5 climb from two to three channels
        cfg_width = 4'd4;
        clear_sched();
        sched[0] = 4'b0011;
        sched[1] = 4'b0100;
        run_sched();
        wait_valid();
        exp_mask(4'b0111);
        check_bin("R5 climb");

        // R6 R8 gating at the exposure edge (single at phase 2, fold at phase 3)
        cfg_width = 4'd1;
        for (int e = 2; e <= 4; e++) begin
            cfg_expose = TW'(e);
            pulse(4'hF);
            wait_valid();
            exp_mask(4'hF);
            if (e <= 2) for (int c = 0; c < NCH; c++) es[c] = 0;
            if (e <= 3) for (int k = 0; k < NCH-1; k++) ef[k] = 0;
            check_bin($sformatf("R6 R8 expose%0d", e));
        end

        // R7 bin period, strobe length, held outputs stable
        cfg_expose = 8'd16;
        cfg_cycle  = 8'd16;
        wait_valid();
        begin
            int gap;
            logic [NCH*CW-1:0] snap;
            snap = cnt_single;
            @(negedge clk);
            chk(int'(res_valid), 0, "R7 strobe one cycle");
            pulse(4'h3);
            repeat (4) @(negedge clk);
            chk(int'(cnt_single), int'(snap), "R7 outputs held inside bin");
            gap = 6;
            while (!res_valid) begin
                @(negedge clk);
                gap++;
            end
            chk(gap, 16, "R7 bin period");
            exp_mask(4'h3);
            check_bin("R7 result after short bin");
        end

        // R8 no blind cycle at the boundary
        cfg_width = 4'd1;
        repeat (13) @(negedge clk);
        pulse(4'b0001);
        wait_valid();
        exp_mask(4'b0001);
        ef[0] = 0;
        chk(int'(cnt_single[CW-1:0]), 1, "R8 last-cycle event in closing bin");
        repeat (14) @(negedge clk);
        pulse(4'b0001);
        wait_valid();
        chk(int'(cnt_single[CW-1:0]), 0, "R8 first-cycle event not in closing bin");
        wait_valid();
        chk(int'(cnt_single[CW-1:0]), 1, "R8 first-cycle event in new bin");

        // R9 R10 saturation and overflow flag
        cfg_expose = 8'd128;
        cfg_cycle  = 8'd128;
        wait_valid();
        for (int n = 15; n <= 16; n++) begin
            for (int p = 0; p < n; p++) begin
                pulse(4'hF);
                repeat (3) @(negedge clk);
            end
            wait_valid();
            for (int c = 0; c < NCH; c++) es[c] = 15;
            for (int k = 0; k < NCH-1; k++) ef[k] = 15;
            eo = (n == 16) ? 1 : 0;
            check_bin($sformatf("R9 R10 %0d events", n));
        end
        wait_valid();
        exp_mask(4'd0);
        check_bin("R10 flags clear next bin");

        done = 1;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

endmodule